// File: doc/BRIEF.md
# Serial Receiver with Idle-Timeout FIFO

This block receives asynchronous serial characters, eight data bits sent least significant bit first, and places them in a 16-entry receive queue. The receiver is paced by a tick that runs at sixteen times the bit rate. The CPU pops bytes through a read strobe and sees the fill count directly. A trigger flag shows when the fill count has reached a selectable level.

When fewer bytes than the trigger level are waiting and the line has been quiet for fifteen bit times, the block raises a sticky data-ready flag. Without it, a short tail of a message would sit in the queue and the CPU would never be told. Software clears the flag by writing a zero to it after the queue has been emptied.

A break condition (an all-zero character whose stop bit is also zero) is reported on its own flag and is not stored. The receiver then waits for the line to return high before it hunts for the next start bit. A character that arrives while the queue is full is discarded, and a sticky overrun flag is raised.

Top module: `serial_rx_idle_fifo`

## Requirements
- R1: A frame is a low start bit that is still low at its midpoint (8 ticks after the falling edge is seen), then 8 data bits sampled every 16 ticks, least significant bit first, then a stop bit. Received bytes leave the queue in arrival order: `rdata_o` shows the oldest byte, and a one-cycle `rd_i` pulse removes it.
- R2: `fill_o` ranges from 0 to 16. `trig_o` is high exactly when `fill_o` is at least the trigger level, where `trig_sel_i` 0, 1, 2 and 3 select 1, 4, 8 and 14 bytes.
- R3: A `rd_i` pulse while the queue is empty leaves `fill_o` at 0.
- R4: A byte completed while 16 bytes are held is dropped, and the first 16 bytes are kept intact. The byte sets `ovr_o`, which stays set until a write with `wdata_i[1]` = 0.
- R5: `rdy_o` rises when the queue holds at least one byte but fewer than the trigger level, and 240 ticks (15 bit times) have passed since the stop-bit sample of the last frame. The timer is held at zero while the queue is empty.
- R6: `rdy_o` stays low while the fill count is at or above the trigger level, and also while fewer than 240 ticks have passed since the last stop-bit sample.
- R7: Once set, `rdy_o` stays set. A write with `wdata_i[0]` = 0 clears it only when the queue is empty. A write of 1 to that bit, or a write of 0 while bytes remain, leaves it unchanged.
- R8: After reset, `fill_o` is 0 and `trig_o`, `rdy_o`, `brk_o` and `ovr_o` are all low.
- R9: With `two_stop_i` high, only the first stop bit is checked. A low second stop bit neither starts a new frame nor adds a byte.
- R10: A frame with data 0x00 and a low stop bit sets `brk_o` and is not stored. The receiver waits for the line to go high, and `brk_o` clears then. A later well-formed 0x00 frame is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rxd_i | input | 1 | Serial line, idle high |
| tick16_i | input | 1 | Oversampling strobe, 16 per bit time |
| trig_sel_i | input | 2 | Trigger level select (1/4/8/14) |
| two_stop_i | input | 1 | Frames carry two stop bits |
| rd_i | input | 1 | Pop the oldest byte |
| wr_i | input | 1 | Status write strobe |
| wdata_i | input | 2 | Status write data: bit0 data-ready, bit1 overrun; 0 clears |
| rdata_o | output | 8 | Oldest byte in the queue |
| fill_o | output | 5 | Bytes held |
| trig_o | output | 1 | Fill count at or above trigger level |
| rdy_o | output | 1 | Idle timeout with a partial batch |
| brk_o | output | 1 | Break in progress |
| ovr_o | output | 1 | Sticky overrun |

## Verification
A wrong read or write pointer shows as a byte out of order, or as a wrong `fill_o`, on the very next pop. A wrong bit counter or sample point in the frame engine corrupts the byte that `rdata_o` shows as soon as the stop bit has been sampled. An idle timer with the wrong limit moves the rise of `rdy_o` by whole bit times. To catch this, the flag is checked at points well before and well after the 240-tick boundary. A wrong clear rule or a stuck break flag shows at the first status write, or at the first high line level that follows.

// File: rtl/srx_pkg.sv
package srx_pkg;

   typedef enum logic [2:0] {
      FR_IDLE,
      FR_START,
      FR_DATA,
      FR_STOP,
      FR_STOP2,
      FR_MARK
   } fr_state_t;

   // Trigger encoding: 0 -> 1, 1 -> 4, 2 -> 8, 3 -> 14 bytes.
   function automatic logic [7:0] trig_level(input logic [1:0] sel);
      case (sel)
         2'd0:    return 8'd1;
         2'd1:    return 8'd4;
         2'd2:    return 8'd8;
         default: return 8'd14;
      endcase
   endfunction

endpackage

// File: rtl/srx_framer.sv
module srx_framer #(
   parameter int OSR  = 16,
   parameter int DW   = 8,
   parameter int SYNC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rxd_i,
   input  logic          tick_i,
   input  logic          two_stop_i,
   output logic          done_o,
   output logic [DW-1:0] data_o,
   output logic          stop_ok_o,
   output logic          line_o
);
   import srx_pkg::*;

   localparam int CTW = $clog2(OSR + OSR / 2);
   localparam int BW  = (DW > 1) ? $clog2(DW) : 1;
   localparam logic [CTW-1:0] C_HALF = CTW'(OSR / 2 - 1);
   localparam logic [CTW-1:0] C_BIT  = CTW'(OSR - 1);
   localparam logic [CTW-1:0] C_TAIL = CTW'(OSR + OSR / 2 - 1);
   localparam logic [BW-1:0]  C_LAST = BW'(DW - 1);

   logic            rx_s;
   fr_state_t       st;
   logic [CTW-1:0]  cnt;
   logic [BW-1:0]   bits;
   logic [DW-1:0]   shreg;

   generate
      if (SYNC == 0) begin : g_nosync
         assign rx_s = rxd_i;
      end else begin : g_sync
         logic [SYNC-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '1;
            else        sr <= (sr << 1) | SYNC'(rxd_i);
         end
         assign rx_s = sr[SYNC-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= FR_IDLE;
         cnt       <= '0;
         bits      <= '0;
         shreg     <= '0;
         done_o    <= 1'b0;
         stop_ok_o <= 1'b1;
      end else begin
         done_o <= 1'b0;
         if (tick_i) begin
            case (st)
               FR_IDLE: if (!rx_s) begin
                  st  <= FR_START;
                  cnt <= '0;
               end
               FR_START: if (cnt == C_HALF) begin
                  cnt  <= '0;
                  bits <= '0;
                  st   <= rx_s ? FR_IDLE : FR_DATA;
               end else cnt <= cnt + 1'b1;
               FR_DATA: if (cnt == C_BIT) begin
                  cnt   <= '0;
                  shreg <= {rx_s, shreg[DW-1:1]};
                  bits  <= bits + 1'b1;
                  if (bits == C_LAST) st <= FR_STOP;
               end else cnt <= cnt + 1'b1;
               FR_STOP: if (cnt == C_BIT) begin
                  cnt       <= '0;
                  done_o    <= 1'b1;
                  stop_ok_o <= rx_s;
                  if (!rx_s)           st <= FR_MARK;
                  else if (two_stop_i) st <= FR_STOP2;
                  else                 st <= FR_IDLE;
               end else cnt <= cnt + 1'b1;
               FR_STOP2: if (cnt == C_TAIL) begin
                  cnt <= '0;
                  st  <= FR_IDLE;
               end else cnt <= cnt + 1'b1;
               FR_MARK: if (rx_s) st <= FR_IDLE;
               default: st <= FR_IDLE;
            endcase
         end
      end
   end

   assign data_o = shreg;
   assign line_o = rx_s;

   AST_DONE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(tick_i)); // R1

endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
   parameter int DEPTH = 16,
   parameter int DW    = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push_i,
   input  logic [DW-1:0]              wdata_i,
   input  logic                       pop_i,
   input  logic                       clr_ovr_i,
   output logic [DW-1:0]              rdata_o,
   output logic [$clog2(DEPTH+1)-1:0] count_o,
   output logic                       empty_o,
   output logic                       ovr_o
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] C_FULL = CW'(DEPTH);

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic          full, do_push, do_pop;

   assign full    = (count_o == C_FULL);
   assign empty_o = (count_o == '0);
   assign do_push = push_i && !full;
   assign do_pop  = pop_i && !empty_o;
   assign rdata_o = mem[rptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr    <= '0;
         rptr    <= '0;
         count_o <= '0;
         ovr_o   <= 1'b0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count_o <= count_o + 1'b1;
            2'b01:   count_o <= count_o - 1'b1;
            default: count_o <= count_o;
         endcase
         if (push_i && full) ovr_o <= 1'b1;
         else if (clr_ovr_i) ovr_o <= 1'b0;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count_o <= C_FULL); // R2
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && empty_o && !push_i) |=> (count_o == '0)); // R3
   AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_o) |-> $past(push_i && full)); // R4

endmodule

// File: rtl/srx_idle_flag.sv
module srx_idle_flag #(
   parameter int OSR       = 16,
   parameter int IDLE_BITS = 15,
   parameter int CW        = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic          frame_i,
   input  logic [CW-1:0] fill_i,
   input  logic [CW-1:0] trig_i,
   input  logic          empty_i,
   input  logic          wr_i,
   input  logic          wbit_i,
   output logic          rdy_o
);
   localparam int LIMIT = OSR * IDLE_BITS;
   localparam int TW    = $clog2(LIMIT + 1);
   localparam logic [TW-1:0] C_LIM = TW'(LIMIT);

   logic [TW-1:0] tmr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr   <= '0;
         rdy_o <= 1'b0;
      end else begin
         if (frame_i || empty_i)           tmr <= '0;
         else if (tick_i && tmr != C_LIM)  tmr <= tmr + 1'b1;
         if (wr_i && !wbit_i && empty_i)
            rdy_o <= 1'b0;
         else if (tmr == C_LIM && !empty_i && fill_i < trig_i)
            rdy_o <= 1'b1;
      end
   end

   AST_RDY_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy_o) |-> ($past(fill_i) != '0 && $past(fill_i) < $past(trig_i))); // R5
   AST_RDY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rdy_o) |-> $past(wr_i && !wbit_i && empty_i)); // R7

endmodule

// File: rtl/serial_rx_idle_fifo.sv
module serial_rx_idle_fifo #(
   parameter int DEPTH     = 16,
   parameter int DW        = 8,
   parameter int OSR       = 16,
   parameter int IDLE_BITS = 15,
   parameter int SYNC      = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       rxd_i,
   input  logic                       tick16_i,
   input  logic [1:0]                 trig_sel_i,
   input  logic                       two_stop_i,
   input  logic                       rd_i,
   input  logic                       wr_i,
   input  logic [1:0]                 wdata_i,
   output logic [DW-1:0]              rdata_o,
   output logic [$clog2(DEPTH+1)-1:0] fill_o,
   output logic                       trig_o,
   output logic                       rdy_o,
   output logic                       brk_o,
   output logic                       ovr_o
);
   localparam int CW = $clog2(DEPTH + 1);

   initial begin
      assert (DEPTH >= 14 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two of at least 14");
      assert (OSR >= 4 && OSR % 2 == 0) else $error("OSR must be even and >= 4");
      assert (IDLE_BITS >= 1) else $error("IDLE_BITS must be positive");
   end

   logic          fr_done, fr_stop_ok, fr_line, fr_zero, push, empty;
   logic [DW-1:0] fr_data;
   logic [CW-1:0] trig_lvl;

   srx_framer #(.OSR(OSR), .DW(DW), .SYNC(SYNC)) u_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .rxd_i      (rxd_i),
      .tick_i     (tick16_i),
      .two_stop_i (two_stop_i),
      .done_o     (fr_done),
      .data_o     (fr_data),
      .stop_ok_o  (fr_stop_ok),
      .line_o     (fr_line)
   );

   assign fr_zero = (fr_data == '0);
   assign push    = fr_done && !(fr_zero && !fr_stop_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             brk_o <= 1'b0;
      else if (fr_done && fr_zero && !fr_stop_ok) brk_o <= 1'b1;
      else if (fr_line)                       brk_o <= 1'b0;
   end

   srx_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_i    (push),
      .wdata_i   (fr_data),
      .pop_i     (rd_i),
      .clr_ovr_i (wr_i && !wdata_i[1]),
      .rdata_o   (rdata_o),
      .count_o   (fill_o),
      .empty_o   (empty),
      .ovr_o     (ovr_o)
   );

   assign trig_lvl = CW'(srx_pkg::trig_level(trig_sel_i));
   assign trig_o   = (fill_o >= trig_lvl);

   srx_idle_flag #(.OSR(OSR), .IDLE_BITS(IDLE_BITS), .CW(CW)) u_idle (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick16_i),
      .frame_i (fr_done),
      .fill_i  (fill_o),
      .trig_i  (trig_lvl),
      .empty_i (empty),
      .wr_i    (wr_i),
      .wbit_i  (wdata_i[0]),
      .rdy_o   (rdy_o)
   );

   AST_BRK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (fr_done && fr_zero && !fr_stop_ok && !rd_i) |=> $stable(fill_o)); // R10

endmodule

// File: tb/serial_rx_idle_fifo_bench.sv
module serial_rx_idle_fifo_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rxd = 1'b1;
   logic       tick = 1'b0;
   logic [1:0] trig_sel = 2'd1;
   logic       two_stop = 1'b0;
   logic       rd = 1'b0;
   logic       wr = 1'b0;
   logic [1:0] wdata = 2'b11;
   logic [7:0] rdata;
   logic [4:0] fill;
   logic       trig, rdy, brk, ovr;
   logic [1:0] tc = 2'd0;
   int checks = 0;
   int errors = 0;
   bit done_flag = 1'b0;

   always #5 clk = ~clk;

   always @(posedge clk) begin
      tc   <= tc + 2'd1;
      tick <= (tc == 2'd3);
   end

   serial_rx_idle_fifo u_serial_rx_idle_fifo (
      .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .tick16_i(tick),
      .trig_sel_i(trig_sel), .two_stop_i(two_stop), .rd_i(rd), .wr_i(wr),
      .wdata_i(wdata), .rdata_o(rdata), .fill_o(fill), .trig_o(trig),
      .rdy_o(rdy), .brk_o(brk), .ovr_o(ovr)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic line_bit(input logic v);
      @(negedge clk) rxd = v;
      repeat (63) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] b, input logic s1,
                             input logic two, input logic s2);
      line_bit(1'b0);
      for (int i = 0; i < 8; i++) line_bit(b[i]);
      line_bit(s1);
      if (two) line_bit(s2);
      line_bit(1'b1);
   endtask

   task automatic send_byte(input logic [7:0] b);
      send_frame(b, 1'b1, 1'b0, 1'b1);
   endtask

   task automatic wait_ticks(input int n);
      repeat (4 * n) @(negedge clk);
   endtask

   task automatic pop(output logic [7:0] v);
      @(negedge clk);
      v  = rdata;
      rd = 1'b1;
      @(negedge clk) rd = 1'b0;
   endtask

   task automatic wr_status(input logic [1:0] v);
      @(negedge clk) begin wr = 1'b1; wdata = v; end
      @(negedge clk) begin wr = 1'b0; wdata = 2'b11; end
      @(negedge clk);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      check("R8 fill", fill, 0);
      check("R8 flags", {trig, rdy, brk, ovr}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_empty_read;
      logic [7:0] v;
      pop(v);
      check("R3 fill after empty pop", fill, 0);
   endtask

   task automatic t_order_timeout;
      logic [7:0] v;
      trig_sel = 2'd1;
      send_byte(8'h3C);
      send_byte(8'hA5);
      check("R1 fill after two", fill, 2);
      wait_ticks(100);
      check("R6 rdy before 15 bits", rdy, 0);
      wait_ticks(200);
      check("R5 rdy after 15 bits", rdy, 1);
      wr_status(2'b10);
      check("R7 write 0 with data left", rdy, 1);
      pop(v);
      check("R1 first byte", v, 8'h3C);
      pop(v);
      check("R1 second byte", v, 8'hA5);
      wr_status(2'b11);
      check("R7 write 1 no effect", rdy, 1);
      wr_status(2'b10);
      check("R7 write 0 when empty", rdy, 0);
      wait_ticks(300);
      check("R5 empty holds timer", rdy, 0);
   endtask

   task automatic t_trigger;
      logic [7:0] v;
      trig_sel = 2'd1;
      for (int i = 0; i < 4; i++) send_byte(8'h10 + 8'(i));
      check("R2 trig at level 4", trig, 1);
      wait_ticks(300);
      check("R6 rdy low at trigger", rdy, 0);
      trig_sel = 2'd2;
      repeat (3) @(negedge clk);
      check("R2 trig below level 8", trig, 0);
      check("R5 rdy once fill below level", rdy, 1);
      trig_sel = 2'd3;
      @(negedge clk);
      check("R2 trig below level 14", trig, 0);
      trig_sel = 2'd0;
      @(negedge clk);
      check("R2 trig at level 1", trig, 1);
      for (int i = 0; i < 4; i++) begin
         pop(v);
         check("R1 trigger batch order", v, 8'h10 + i);
      end
      check("R2 trig empty level 1", trig, 0);
      wr_status(2'b10);
      check("R7 cleared after drain", rdy, 0);
   endtask

   task automatic t_two_stop;
      logic [7:0] v;
      two_stop = 1'b1;
      send_frame(8'hA5, 1'b1, 1'b1, 1'b0);
      wait_ticks(40);
      check("R9 one byte with low second stop", fill, 1);
      pop(v);
      check("R9 byte value", v, 8'hA5);
      check("R9 no break", brk, 0);
      two_stop = 1'b0;
   endtask

   task automatic t_break;
      logic [7:0] v;
      for (int i = 0; i < 12; i++) line_bit(1'b0);
      check("R10 break flagged", brk, 1);
      check("R10 break byte dropped", fill, 0);
      line_bit(1'b1);
      line_bit(1'b1);
      check("R10 break cleared on mark", brk, 0);
      send_byte(8'h00);
      check("R10 zero stored after break", fill, 1);
      pop(v);
      check("R10 zero value", v, 0);
   endtask

   task automatic t_overrun;
      logic [7:0] v;
      trig_sel = 2'd3;
      for (int i = 0; i < 17; i++) send_byte(8'h40 + 8'(i));
      check("R4 fill capped", fill, 16);
      check("R4 overrun set", ovr, 1);
      for (int i = 0; i < 16; i++) begin
         pop(v);
         check("R4 kept bytes", v, 8'h40 + i);
      end
      check("R4 ovr sticky", ovr, 1);
      wr_status(2'b00);
      check("R4 ovr cleared", ovr, 0);
      check("R7 rdy low after clear", rdy, 0);
   endtask

   task automatic finish_run;
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_empty_read();
      t_order_timeout();
      t_trigger();
      t_two_stop();
      t_break();
      t_overrun();
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

endmodule